// File: doc/BRIEF.md
# Warm and Cold Reset Sequencer

This block steps a microcontroller through its system reset, starting from an external active-low reset request. The request passes through a two-stage synchronizer and then a glitch filter. A second input, the pulldown sense, is read when the request is accepted. If it is high, the reset is warm: hold states are cancelled and the bus access in progress may finish, within a bounded window. If it is low, the reset is cold and the sequencer enters reset at once.

While reset is active, the pins are tri-stated, the reset output is low and the bus strobes are forced inactive. When the request is released, the sequencer waits a few cycles and then captures a 16-bit start-up configuration word. The wait depends on the clock-select field of that word. If the clock-select field differs from the one captured before, the sequencer waits for the PLL to report lock. When flash is in use, it also waits for the flash to report that it is ready. It then issues a one-cycle request to start fetching at address zero. The block is clocked at TCL rate, so one CPU clock spans two cycles.

Top module: `rst_seq`

## Requirements
- R1: When a request is accepted, a high synchronized `pd_sense` selects a warm reset, which goes through the drain state (2). A low `pd_sense` selects a cold reset, which goes straight to the in-reset state (3).
- R2: A synchronized low on `ext_rst_n` lasting fewer than FILT_CYC cycles is ignored. The state returns to run (7), `rst_out_n` stays high and `fetch_start` stays low.
- R3: A request is accepted after FILT_CYC consecutive low cycles. FILT_CYC = max(MIN_TCL, ceil(CLK_MHZ*FILT_NS/1000)), and MIN_TCL defaults to 4.
- R4: The drain state (2) ends on the cycle after `bus_idle` is seen. Without `bus_idle` it ends after DRAIN_MAX (12) cycles. `hold_cancel` is high exactly while in the drain state.
- R5: In states idle (0) and 3 to 6, `io_hiz`=1, `rst_out_n`=0 and `strobe_off`=1. In states 1, 2 and 7 all three are released.
- R6: The latch state (4) lasts 3+min(sel,5) cycles, where sel is `cfg_port[15:13]`. In its last cycle, `cfg_port` is captured into `cfg_word`, which holds its value at all other times.
- R7: If the captured sel differs from the previously captured sel, the sequencer waits in state 5 (`pll_sync_req`=1) until `pll_locked` is seen. Otherwise it skips state 5.
- R8: With `flash_en`=1, the sequencer waits in state 6 until `flash_done` is seen. With `flash_en`=0, it skips state 6.
- R9: `fetch_start` pulses for exactly one cycle, on the first cycle of state 7 after a reset. It does not pulse after a rejected pulse.
- R10: `por_n` low gives state idle (0) and `cfg_word`=0. State codes are 0 idle, 1 filter, 2 drain, 3 in-reset, 4 latch, 5 PLL wait, 6 flash wait, 7 run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCL-rate clock |
| por_n | input | 1 | Power-on reset for the sequencer itself, active low |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| pd_sense | input | 1 | Pulldown sense: high selects warm, low selects cold |
| bus_idle | input | 1 | Bus reports that the access in flight has ended |
| pll_locked | input | 1 | PLL reports lock |
| flash_en | input | 1 | Internal flash in use |
| flash_done | input | 1 | Flash initialisation complete |
| cfg_port | input | 16 | Parallel start-up configuration word |
| state_o | output | 3 | Sequencer state code |
| io_hiz | output | 1 | Tri-state request for the I/O pins |
| rst_out_n | output | 1 | Reset output, active low |
| strobe_off | output | 1 | Forces the address-latch, read and write strobes inactive |
| hold_cancel | output | 1 | Cancels pending hold states during the drain |
| cfg_word | output | 16 | Captured configuration word |
| pll_sync_req | output | 1 | Waiting for the PLL to resynchronize |
| fetch_start | output | 1 | One-cycle request to start fetching at address zero |

## Verification
The bench builds the block with FILT_NS=150 at CLK_MHZ=40, which gives a filter length of 6 cycles. Pulses of 3, 5, 6 and more cycles therefore fall on both sides of the acceptance boundary within a short run. DRAIN_MAX keeps its value of 12, so the drain timeout is reached when `bus_idle` is held low. Clock-select values of 0, 1, 5 and 7 cover the shortest and the clamped longest capture delays, with and without a PLL wait.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_FILTER     = 3'd1,
    ST_DRAIN      = 3'd2,
    ST_IN_RESET   = 3'd3,
    ST_LATCH      = 3'd4,
    ST_WAIT_PLL   = 3'd5,
    ST_WAIT_FLASH = 3'd6,
    ST_RUN        = 3'd7
  } seq_state_e;

  // Low cycles required to accept a request: rounded-up clock count, floored at min_c
  function automatic int filt_cycles(int mhz, int ns, int min_c);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < min_c) ? min_c : c;
  endfunction

  // Cycles from release to capture, set by the clock-select field
  function automatic int latch_delay(int sel);
    return 3 + ((sel > 5) ? 5 : sel);
  endfunction

  // States in which the chip is held in reset
  function automatic logic in_reset_group(seq_state_e s);
    return (s == ST_IDLE) || (s == ST_IN_RESET) || (s == ST_LATCH) ||
           (s == ST_WAIT_PLL) || (s == ST_WAIT_FLASH);
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_seq_cfg.sv
module rst_seq_cfg #(
  parameter int              CFG_W  = 16,
  parameter int              SEL_HI = 15,
  parameter int              SEL_LO = 13,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] q,
  output logic             sel_changed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= CFG_RST;
    else if (cap) q <= din;
  end

  assign sel_changed = din[SEL_HI:SEL_LO] != q[SEL_HI:SEL_LO];

  // R6: the word moves only on a capture
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));
  p_cfg_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(din)));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int FILT_CYC  = 20,
  parameter int DRAIN_MAX = 12,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs_low,
  input  logic          pd_hi,
  input  logic          bus_idle,
  input  logic          pll_locked,
  input  logic          flash_en,
  input  logic          flash_done,
  input  logic [CW-1:0] lat_load,
  input  logic          sel_changed,
  output seq_state_e    state,
  output logic          cap,
  output logic          fetch_start
);
  localparam logic [CW-1:0] FILT_LAST  = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_MAX - 1);

  seq_state_e    nxt;
  logic [CW-1:0] cnt, cnt_n;
  logic          accept_evt, reject_evt, drain_end_evt, enter_run_evt;

  assign accept_evt    = (state == ST_FILTER) && rs_low && (cnt == FILT_LAST);
  assign reject_evt    = (state == ST_FILTER) && !rs_low;
  assign drain_end_evt = (state == ST_DRAIN) && (bus_idle || cnt == DRAIN_LAST);
  assign cap           = (state == ST_LATCH) && (cnt == '0);

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    unique case (state)
      ST_IDLE, ST_IN_RESET:
        if (!rs_low) begin nxt = ST_LATCH; cnt_n = lat_load; end
      ST_RUN:
        if (rs_low) begin nxt = ST_FILTER; cnt_n = CW'(1); end
      ST_FILTER:
        if (reject_evt)      nxt = ST_RUN;
        else if (accept_evt) begin nxt = pd_hi ? ST_DRAIN : ST_IN_RESET; cnt_n = '0; end
        else                 cnt_n = cnt + CW'(1);
      ST_DRAIN:
        if (drain_end_evt) nxt = ST_IN_RESET;
        else               cnt_n = cnt + CW'(1);
      ST_LATCH:
        if (cap) nxt = sel_changed ? ST_WAIT_PLL : (flash_en ? ST_WAIT_FLASH : ST_RUN);
        else     cnt_n = cnt - CW'(1);
      ST_WAIT_PLL:
        if (pll_locked) nxt = flash_en ? ST_WAIT_FLASH : ST_RUN;
      ST_WAIT_FLASH:
        if (flash_done) nxt = ST_RUN;
      default: nxt = ST_IDLE;
    endcase
  end

  assign enter_run_evt = (nxt == ST_RUN) && in_reset_group(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      fetch_start <= 1'b0;
    end else begin
      state       <= nxt;
      cnt         <= cnt_n;
      fetch_start <= enter_run_evt;
    end
  end

  // R1: the pulldown sense picks the path at acceptance
  p_warm_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && pd_hi) |=> (state == ST_DRAIN));
  p_cold_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !pd_hi) |=> (state == ST_IN_RESET));
  // R2: a short pulse returns to run
  p_short_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (state == ST_RUN));
  // R4: the drain window is bounded
  p_drain_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DRAIN) && (cnt == DRAIN_LAST)) |=> (state == ST_IN_RESET));
  // R7: no exit from the PLL wait without lock
  p_pll_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT_PLL) && !pll_locked) |=> (state == ST_WAIT_PLL));
  // R9: the fetch request follows a real reset only
  p_fetch_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> ((state == ST_RUN) && in_reset_group($past(state))));
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 40,
  parameter int FILT_NS     = 500,
  parameter int MIN_TCL     = 4,
  parameter int DRAIN_MAX   = 12,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 16,
  parameter int SEL_HI      = 15,
  parameter int SEL_LO      = 13
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             pd_sense,
  input  logic             bus_idle,
  input  logic             pll_locked,
  input  logic             flash_en,
  input  logic             flash_done,
  input  logic [CFG_W-1:0] cfg_port,
  output logic [2:0]       state_o,
  output logic             io_hiz,
  output logic             rst_out_n,
  output logic             strobe_off,
  output logic             hold_cancel,
  output logic [CFG_W-1:0] cfg_word,
  output logic             pll_sync_req,
  output logic             fetch_start
);
  localparam int FILT_CYC = filt_cycles(CLK_MHZ, FILT_NS, MIN_TCL);
  localparam int CMAX     = (FILT_CYC > DRAIN_MAX) ? FILT_CYC : DRAIN_MAX;
  localparam int CW       = $clog2(((CMAX > 8) ? CMAX : 8) + 1);

  logic [1:0]    sync_q;
  logic          rs_low, pd_hi, cap, sel_changed;
  logic [CW-1:0] lat_load;
  seq_state_e    state;

  rst_seq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk(clk), .rst_n(por_n), .d({pd_sense, ext_rst_n}), .q(sync_q)
  );

  assign rs_low   = !sync_q[0];
  assign pd_hi    = sync_q[1];
  assign lat_load = CW'(latch_delay(int'(cfg_port[SEL_HI:SEL_LO])) - 1);

  rst_seq_ctrl #(.FILT_CYC(FILT_CYC), .DRAIN_MAX(DRAIN_MAX), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(por_n), .rs_low(rs_low), .pd_hi(pd_hi),
    .bus_idle(bus_idle), .pll_locked(pll_locked), .flash_en(flash_en),
    .flash_done(flash_done), .lat_load(lat_load), .sel_changed(sel_changed),
    .state(state), .cap(cap), .fetch_start(fetch_start)
  );

  rst_seq_cfg #(.CFG_W(CFG_W), .SEL_HI(SEL_HI), .SEL_LO(SEL_LO)) u_cfg (
    .clk(clk), .rst_n(por_n), .cap(cap), .din(cfg_port),
    .q(cfg_word), .sel_changed(sel_changed)
  );

  assign state_o      = state;
  assign io_hiz       = in_reset_group(state);
  assign rst_out_n    = !in_reset_group(state);
  assign strobe_off   = in_reset_group(state);
  assign hold_cancel  = (state == ST_DRAIN);
  assign pll_sync_req = (state == ST_WAIT_PLL);

  // R5: pins released whenever the core runs
  p_run_released_r5: assert property (@(posedge clk) disable iff (!por_n)
    fetch_start |-> (rst_out_n && !io_hiz && !strobe_off));
endmodule

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int FILT = 6;

  logic        clk = 1'b0;
  logic        por_n, ext_rst_n, pd_sense, bus_idle, pll_locked, flash_en, flash_done;
  logic [15:0] cfg_port, cfg_word;
  logic [2:0]  state_o;
  logic        io_hiz, rst_out_n, strobe_off, hold_cancel, pll_sync_req, fetch_start;

  int n_tests = 0, n_fail = 0;
  int n_fetch, n_latch, n_pll, n_flash, n_drain, n_rstlow, bad_out = 0, bad_fetch = 0;
  int pll_cyc = 0, flash_cyc = 0;
  logic [2:0] prev_st = 3'd0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  rst_seq #(.CLK_MHZ(40), .FILT_NS(150)) uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pd_sense(pd_sense),
    .bus_idle(bus_idle), .pll_locked(pll_locked), .flash_en(flash_en),
    .flash_done(flash_done), .cfg_port(cfg_port), .state_o(state_o),
    .io_hiz(io_hiz), .rst_out_n(rst_out_n), .strobe_off(strobe_off),
    .hold_cancel(hold_cancel), .cfg_word(cfg_word), .pll_sync_req(pll_sync_req),
    .fetch_start(fetch_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: counts cycles per state and answers the PLL / flash handshakes
  always @(negedge clk) begin
    if (por_n) begin
      logic grp;
      grp = (state_o == 3'd0) || (state_o >= 3'd3 && state_o <= 3'd6);
      if (grp != (io_hiz && !rst_out_n && strobe_off)) bad_out++;          // R5
      if (!grp && (io_hiz || !rst_out_n || strobe_off)) bad_out++;         // R5
      if ((state_o == 3'd2) != hold_cancel) bad_out++;                      // R4
      if ((state_o == 3'd5) != pll_sync_req) bad_out++;                     // R7
      if (fetch_start) begin
        n_fetch++;
        if (state_o != 3'd7 || prev_st == 3'd7 || prev_st == 3'd1) bad_fetch++;
      end
      if (!rst_out_n) n_rstlow++;
      if (state_o == 3'd2) n_drain++;
      if (state_o == 3'd4) n_latch++;
      if (state_o == 3'd5) begin n_pll++; pll_cyc++; pll_locked = (pll_cyc >= 3); end
      else begin pll_cyc = 0; pll_locked = 1'b0; end
      if (state_o == 3'd6) begin n_flash++; flash_cyc++; flash_done = (flash_cyc >= 2); end
      else begin flash_cyc = 0; flash_done = 1'b0; end
      prev_st = state_o;
    end
  end

  task automatic clear_counts();
    @(posedge clk); #1;
    n_fetch = 0; n_latch = 0; n_pll = 0; n_flash = 0; n_drain = 0; n_rstlow = 0;
  endtask

  // {len[7:0], pd, bus_idle, flash_en, cfg[15:0]}
  localparam logic [26:0] VEC [6] = '{
    {8'd3,  1'b1, 1'b1, 1'b0, 16'h2000},
    {8'd5,  1'b1, 1'b1, 1'b0, 16'hA5A5},
    {8'd6,  1'b1, 1'b1, 1'b0, 16'h2345},
    {8'd9,  1'b0, 1'b1, 1'b1, 16'h3C0F},
    {8'd6,  1'b1, 1'b0, 1'b0, 16'hE001},
    {8'd10, 1'b0, 1'b1, 1'b1, 16'hA0F0}
  };

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; pd_sense = 1'b1; bus_idle = 1'b1;
    pll_locked = 1'b0; flash_en = 1'b0; flash_done = 1'b0; cfg_port = 16'h0000;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 state in reset", int'(state_o), 0);
    chk("R10 cfg_word in reset", int'(cfg_word), 0);
    chk("R5 rst_out_n in reset", int'(rst_out_n), 0);
    chk("R5 io_hiz in reset", int'(io_hiz), 1);
    chk("R9 fetch_start in reset", int'(fetch_start), 0);
    por_n = 1'b1;
    n_fetch = 0; n_latch = 0; n_pll = 0; n_flash = 0; n_drain = 0; n_rstlow = 0;
    repeat (30) @(negedge clk);
    chk("R6 power-up latch cycles sel0", n_latch, 3);
    chk("R7 power-up no pll wait", n_pll, 0);
    chk("R9 power-up fetch pulses", n_fetch, 1);
    chk("R10 run state", int'(state_o), 7);

    begin
      logic [15:0] prev_cfg;
      prev_cfg = 16'h0000;
      for (int i = 0; i < 6; i++) begin
        int len, e_latch, e_drain, e_pll, e_flash, sel;
        logic pd, idl, fl, acc;
        logic [15:0] cfg;
        len = int'(VEC[i][26:19]); pd = VEC[i][18]; idl = VEC[i][17];
        fl = VEC[i][16]; cfg = VEC[i][15:0];
        sel = int'(cfg[15:13]);
        acc = (len >= FILT);                                                 // R3
        e_latch = acc ? 3 + ((sel > 5) ? 5 : sel) : 0;
        e_drain = (acc && pd) ? (idl ? 1 : 12) : 0;
        e_pll   = (acc && cfg[15:13] != prev_cfg[15:13]) ? 3 : 0;
        e_flash = (acc && fl) ? 2 : 0;
        clear_counts();
        @(negedge clk);
        pd_sense = pd; bus_idle = idl; flash_en = fl; cfg_port = cfg;
        ext_rst_n = 1'b0;
        repeat (len) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk($sformatf("R2/R3 case%0d fetch count", i), n_fetch, acc ? 1 : 0);
        chk($sformatf("R2 case%0d rst_out low cycles seen", i), int'(n_rstlow > 0), int'(acc));
        chk($sformatf("R1/R4 case%0d drain cycles", i), n_drain, e_drain);
        chk($sformatf("R6 case%0d latch cycles", i), n_latch, e_latch);
        chk($sformatf("R7 case%0d pll wait cycles", i), n_pll, e_pll);
        chk($sformatf("R8 case%0d flash wait cycles", i), n_flash, e_flash);
        if (acc) prev_cfg = cfg;
        chk($sformatf("R6 case%0d cfg_word", i), int'(cfg_word), int'(prev_cfg));
        chk($sformatf("R10 case%0d final state", i), int'(state_o), 7);
      end
    end

    // Directed: released outputs in run, and monitor tallies
    chk("R5 rst_out_n in run", int'(rst_out_n), 1);
    chk("R5 strobe_off in run", int'(strobe_off), 0);
    chk("R5/R4/R7 output relation errors", bad_out, 0);
    chk("R9 misplaced fetch pulses", bad_fetch, 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule